// File: doc/BRIEF.md
# Function Configuration Header with Base Address Decoding

This block holds the 256-byte configuration space of a single bus function. Software writes it one 32-bit word at a time with per-byte enables, in little-endian byte order. A fixed set of identity bytes cannot be changed by writes. Up to six base address registers (BARs) each have an elaboration-time power-of-two size and a set of fixed type bits. Bit 0 of the type bits selects I/O space when set and memory space when clear.

A command byte turns decoding on for I/O space and for memory space separately. The block turns the stored BAR values and the command byte into a registered table of valid flags and base addresses. It recomputes this table only after a write that can change it. An address presented with a space flag is compared against the table, and a per-BAR hit vector comes back in the same cycle.

Top module: `cfgspace_bar_map`

## Requirements
- R1: After reset, bytes 0x00-0x03 read as parameter ID_WORD, bytes 0x08-0x0B read as CLASS_WORD, byte 0x0E reads as HDR_BYTE and byte 0x3D reads as PIN_BYTE. Each implemented BAR word reads as its type bits. Every other byte reads zero and every bar_valid bit is 0.
- R2: Bytes 0x00-0x03, 0x08-0x0B, 0x0E and 0x3D ignore writes. The other enabled bytes of the same access are still written.
- R3: A write with all four byte enables set to word 4+n (byte offset 0x10+4n, n = 0..5), where BAR n has a nonzero size, stores (data AND NOT(size-1)) OR type bits.
- R4: A BAR write with fewer than four enables, or any write to a BAR of size 0, stores the raw enabled bytes.
- R5: Command byte 0x04 bit 0 enables I/O BARs and bit 1 enables memory BARs. A BAR whose space is disabled has valid 0 and base 0.
- R6: An I/O BAR is invalid when its masked base is 0, when base+size-1 does not exceed the base, or when base+size-1 is 0x10000 or more.
- R7: A memory BAR is invalid when its masked base is 0, when base+size-1 does not exceed the base, or when base+size-1 is 0xFFFFFFFF.
- R8: The mapping table is recomputed one clock after a write that enables byte 0x04 or byte 0x05, or after a full-word BAR write of the kind in R3. No other write changes the table.
- R9: hit[n] is 1 exactly when BAR n is valid, chk_io matches that BAR's space, and chk_addr with its low log2(size) bits cleared equals the BAR's base. A BAR of size 0 never hits.
- R10: rd_data returns the bytes at offsets 4*rd_dw+0..3, with the lowest offset in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one word |
| wr_dw | input | 6 | Word index of the write (byte offset / 4) |
| wr_be | input | 4 | Byte enables, bit i for byte offset 4*wr_dw+i |
| wr_data | input | 32 | Write data, byte i in bits 8i+7:8i |
| rd_dw | input | 6 | Word index read combinationally |
| rd_data | output | 32 | Read data |
| chk_addr | input | 32 | Address to decode |
| chk_io | input | 1 | 1 for an I/O-space address, 0 for memory space |
| bar_valid | output | NBAR | Registered valid flag per BAR |
| bar_base | output | 32*NBAR | Registered base per BAR, BAR n in bits 32n+31:32n |
| hit | output | NBAR | Combinational decode hit per BAR |

## Verification
A write changes storage at the clock edge where wr_en is sampled, so rd_data shows the new bytes from the next falling edge. The mapping table lags one more edge, so valid and base checks wait one extra cycle after a triggering write. hit and rd_data are combinational: the bench sets rd_dw or chk_addr away from the clock edge and samples a moment later. A behavioural model checks every output once per cycle, mid-period, against the same timing.

// File: rtl/cfgspace_bar_map.sv
module cfgspace_bar_map #(
  parameter int NBAR = 6,
  parameter logic [NBAR*32-1:0] BAR_SIZE = {32'h0, 32'h0010_0000, 32'h100, 32'h0, 32'h1000, 32'h10},
  parameter logic [NBAR*4-1:0]  BAR_TYPE = {4'h0, 4'h0, 4'h1, 4'h0, 4'h8, 4'h1},
  parameter logic [31:0] ID_WORD    = 32'hC0DE_5A17,
  parameter logic [31:0] CLASS_WORD = 32'h0780_0003,
  parameter logic [7:0]  HDR_BYTE   = 8'h00,
  parameter logic [7:0]  PIN_BYTE   = 8'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [5:0]         wr_dw,
  input  logic [3:0]         wr_be,
  input  logic [31:0]        wr_data,
  input  logic [5:0]         rd_dw,
  output logic [31:0]        rd_data,
  input  logic [31:0]        chk_addr,
  input  logic               chk_io,
  output logic [NBAR-1:0]    bar_valid,
  output logic [NBAR*32-1:0] bar_base,
  output logic [NBAR-1:0]    hit
);

  localparam int BAR_DW0 = 4;

  logic [7:0] cfg [256];
  logic       remap_q;
  logic [1:0] cmd_en;
  logic [31:0] id_word;

  function automatic logic [31:0] size_of(input logic [5:0] dw);
    size_of = '0;
    for (int k = 0; k < NBAR; k++)
      if (dw == 6'(BAR_DW0 + k)) size_of = BAR_SIZE[k*32 +: 32];
  endfunction

  function automatic logic [3:0] type_of(input logic [5:0] dw);
    type_of = '0;
    for (int k = 0; k < NBAR; k++)
      if (dw == 6'(BAR_DW0 + k)) type_of = BAR_TYPE[k*4 +: 4];
  endfunction

  function automatic logic is_ro(input logic [7:0] a);
    is_ro = (a[7:2] == 6'd0) || (a[7:2] == 6'd2) || (a == 8'h0E) || (a == 8'h3D);
  endfunction

  function automatic logic [7:0] rst_byte(input logic [7:0] a);
    logic [31:0] w;
    w = '0;
    if (a[7:2] == 6'd0) w = ID_WORD;
    else if (a[7:2] == 6'd2) w = CLASS_WORD;
    else if (a == 8'h0E) w = {8'h00, HDR_BYTE, 16'h0000};
    else if (a == 8'h3D) w = {16'h0000, PIN_BYTE, 8'h00};
    else if (size_of(a[7:2]) != 32'd0) w = {28'd0, type_of(a[7:2])};
    rst_byte = w[{a[1:0], 3'b000} +: 8];
  endfunction

  wire [31:0] wr_sz       = size_of(wr_dw);
  wire        full_bar_wr = wr_en && (wr_be == 4'hF) && (wr_sz != 32'd0);
  wire [31:0] bar_wval    = (wr_data & ~(wr_sz - 32'd1)) | {28'd0, type_of(wr_dw)};
  wire        touches_cmd = (wr_dw == 6'd1) && (wr_be[1:0] != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) cfg[i] <= rst_byte(8'(i));
      remap_q <= 1'b0;
    end else begin
      remap_q <= full_bar_wr || (wr_en && touches_cmd);
      if (full_bar_wr) begin
        for (int i = 0; i < 4; i++) cfg[{wr_dw, 2'(i)}] <= bar_wval[8*i +: 8];
      end else if (wr_en) begin
        for (int i = 0; i < 4; i++)
          if (wr_be[i] && !is_ro({wr_dw, 2'(i)})) cfg[{wr_dw, 2'(i)}] <= wr_data[8*i +: 8];
      end
    end
  end

  assign cmd_en  = cfg[4][1:0];
  assign id_word = {cfg[3], cfg[2], cfg[1], cfg[0]};
  assign rd_data = {cfg[{rd_dw, 2'd3}], cfg[{rd_dw, 2'd2}], cfg[{rd_dw, 2'd1}], cfg[{rd_dw, 2'd0}]};

  for (genvar n = 0; n < NBAR; n++) begin : g_bar
    localparam logic [31:0] SZ  = BAR_SIZE[n*32 +: 32];
    localparam logic        IO  = BAR_TYPE[n*4];
    localparam logic [7:0]  OFS = 8'(16 + 4*n);

    logic        v_q;
    logic [31:0] b_q;

    wire [31:0] word  = {cfg[OFS + 8'd3], cfg[OFS + 8'd2], cfg[OFS + 8'd1], cfg[OFS]};
    wire [31:0] base  = word & ~(SZ - 32'd1);
    wire [31:0] last  = base + SZ - 32'd1;
    wire        en    = IO ? cmd_en[0] : cmd_en[1];
    wire        inrng = IO ? (last < 32'h0001_0000) : (last != 32'hFFFF_FFFF);
    wire        ok    = (SZ != 32'd0) && en && (base != 32'd0) && (last > base) && inrng;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        b_q <= '0;
      end else if (remap_q) begin
        v_q <= ok;
        b_q <= ok ? base : 32'd0;
      end
    end

    assign bar_valid[n]         = v_q;
    assign bar_base[n*32 +: 32] = b_q;
    assign hit[n] = v_q && (chk_io == IO) && ((chk_addr & ~(SZ - 32'd1)) == b_q);
  end

endmodule

// File: rtl/cfgspace_bar_map_chk.sv
module cfgspace_bar_map_chk #(
  parameter int NBAR = 6,
  parameter logic [NBAR*32-1:0] BAR_SIZE = '0,
  parameter logic [NBAR*4-1:0]  BAR_TYPE = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NBAR-1:0]    bar_valid,
  input logic [NBAR*32-1:0] bar_base,
  input logic [NBAR-1:0]    hit,
  input logic               chk_io,
  input logic [1:0]         cmd_en,
  input logic [31:0]        id_word,
  input logic               remap_q
);

  // R2
  id_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(id_word));

  // R8
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !remap_q |=> ($stable(bar_valid) && $stable(bar_base)));

  for (genvar n = 0; n < NBAR; n++) begin : g_chk
    localparam logic [31:0] SZ = BAR_SIZE[n*32 +: 32];
    localparam logic        IO = BAR_TYPE[n*4];

    // R5
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bar_valid[n]) |-> $past(IO ? cmd_en[0] : cmd_en[1]));

    if (IO) begin : g_io
      // R6
      io_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bar_valid[n] |-> ((bar_base[n*32 +: 32] != 32'd0) &&
                          (bar_base[n*32 +: 32] + SZ - 32'd1 < 32'h0001_0000)));
    end else begin : g_mem
      // R7
      mem_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bar_valid[n] |-> ((bar_base[n*32 +: 32] != 32'd0) &&
                          (bar_base[n*32 +: 32] + SZ - 32'd1 != 32'hFFFF_FFFF)));
    end

    // R9
    hit_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[n] |-> (bar_valid[n] && (chk_io == IO)));
  end

endmodule

bind cfgspace_bar_map cfgspace_bar_map_chk #(
  .NBAR(NBAR), .BAR_SIZE(BAR_SIZE), .BAR_TYPE(BAR_TYPE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bar_valid(bar_valid), .bar_base(bar_base),
  .hit(hit), .chk_io(chk_io), .cmd_en(cmd_en), .id_word(id_word), .remap_q(remap_q)
);

// File: tb/test_cfgspace_bar_map.sv
module test_cfgspace_bar_map;

  localparam int NB = 6;
  localparam logic [NB*32-1:0] SIZES = {32'h0, 32'h0010_0000, 32'h100, 32'h0, 32'h1000, 32'h10};
  localparam logic [NB*4-1:0]  TYPES = {4'h0, 4'h0, 4'h1, 4'h0, 4'h8, 4'h1};
  localparam logic [31:0] IDW = 32'hC0DE_5A17;
  localparam logic [31:0] CLW = 32'h0780_0003;
  localparam logic [7:0]  HDR = 8'h00;
  localparam logic [7:0]  PIN = 8'h01;

  logic clk = 0, rst_n = 0, wr_en = 0, chk_io = 0;
  logic [5:0] wr_dw = 0, rd_dw = 0;
  logic [3:0] wr_be = 0;
  logic [31:0] wr_data = 0, chk_addr = 0, rd_data;
  logic [NB-1:0] bar_valid, hit;
  logic [NB*32-1:0] bar_base;

  int nchk = 0, nfail = 0;

  cfgspace_bar_map #(.NBAR(NB), .BAR_SIZE(SIZES), .BAR_TYPE(TYPES), .ID_WORD(IDW),
    .CLASS_WORD(CLW), .HDR_BYTE(HDR), .PIN_BYTE(PIN)) i_cfgspace_bar_map (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dw(wr_dw), .wr_be(wr_be), .wr_data(wr_data),
    .rd_dw(rd_dw), .rd_data(rd_data), .chk_addr(chk_addr), .chk_io(chk_io),
    .bar_valid(bar_valid), .bar_base(bar_base), .hit(hit));

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0]  m_cfg [256];
  logic [NB-1:0] m_val;
  logic [31:0] m_base [NB];
  bit m_pend;

  function automatic longint sz(input int n); return longint'(SIZES[n*32 +: 32]); endfunction
  function automatic logic [3:0] ty(input int n); return TYPES[n*4 +: 4]; endfunction
  function automatic bit ro(input int a); return a inside {0, 1, 2, 3, 8, 9, 10, 11, 14, 61}; endfunction

  task automatic m_reset();
    for (int a = 0; a < 256; a++) m_cfg[a] = 8'h00;
    for (int i = 0; i < 4; i++) begin
      m_cfg[i] = IDW[8*i +: 8];
      m_cfg[8+i] = CLW[8*i +: 8];
    end
    m_cfg[14] = HDR;
    m_cfg[61] = PIN;
    for (int n = 0; n < NB; n++) if (sz(n) != 0) m_cfg[16+4*n] = {4'h0, ty(n)};
    m_val = '0;
    for (int n = 0; n < NB; n++) m_base[n] = '0;
    m_pend = 0;
  endtask

  task automatic m_remap();
    for (int n = 0; n < NB; n++) begin
      longint w, b, last, s;
      bit io, en, ok;
      s = sz(n);
      w = longint'({m_cfg[16+4*n+3], m_cfg[16+4*n+2], m_cfg[16+4*n+1], m_cfg[16+4*n]});
      io = ty(n)[0];
      en = io ? m_cfg[4][0] : m_cfg[4][1];
      ok = 0;
      b = 0;
      if (s > 1) begin
        b = w - (w % s);
        last = b + s - 1;
        ok = en && b != 0 && (io ? last < 65536 : last < 64'hFFFF_FFFF);
      end
      m_val[n] = ok;
      m_base[n] = ok ? b[31:0] : 32'd0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      bit trig;
      int n;
      trig = 0;
      if (m_pend) m_remap();
      if (wr_en) begin
        n = int'(wr_dw) - 4;
        if (wr_be == 4'hF && n >= 0 && n < NB && sz(n) != 0) begin
          longint w, v;
          w = longint'(wr_data);
          v = (w - (w % sz(n))) | longint'(ty(n));
          for (int i = 0; i < 4; i++) m_cfg[4*wr_dw+i] = v[8*i +: 8];
          trig = 1;
        end else begin
          for (int i = 0; i < 4; i++)
            if (wr_be[i] && !ro(4*wr_dw+i)) m_cfg[4*wr_dw+i] = wr_data[8*i +: 8];
          if (wr_dw == 1 && wr_be[1:0] != 0) trig = 1;
        end
      end
      m_pend = trig;
    end
  end

  // per-cycle comparison, mid-period
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      logic [NB-1:0] mh;
      for (int n = 0; n < NB; n++) begin
        longint a;
        a = longint'(chk_addr);
        mh[n] = m_val[n] && (chk_io == ty(n)[0]) && sz(n) != 0 && ((a - a % sz(n)) == longint'(m_base[n]));
        check("R8 bar_base", bar_base[n*32 +: 32], m_base[n]);
      end
      check("R8 bar_valid", 32'(bar_valid), 32'(m_val));
      check("R9 hit", 32'(hit), 32'(mh));
      check("R10 rd_data", rd_data,
            {m_cfg[4*rd_dw+3], m_cfg[4*rd_dw+2], m_cfg[4*rd_dw+1], m_cfg[4*rd_dw]});
    end
  end

  task automatic wr(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_dw = dw; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic settle(); @(negedge clk); endtask

  task automatic rd(input logic [5:0] dw, output logic [31:0] v);
    rd_dw = dw; #1; v = rd_data;
  endtask

  task automatic probe(input logic [31:0] a, input logic io);
    chk_addr = a; chk_io = io; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd1, 32'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    // R1 reset contents
    rd(0, v);  check("R1 id word", v, IDW);
    rd(2, v);  check("R1 class word", v, CLW);
    rd(3, v);  check("R1 header byte", v, {8'h00, HDR, 16'h0000});
    rd(15, v); check("R1 pin byte", v, {16'h0000, PIN, 8'h00});
    rd(4, v);  check("R1 bar0 type", v, 32'h1);
    rd(5, v);  check("R1 bar1 type", v, 32'h8);
    rd(6, v);  check("R1 bar2 unimpl", v, 32'h0);
    check("R1 valid", 32'(bar_valid), 32'h0);
    // R2 read-only bytes
    wr(0, 4'hF, 32'hFFFF_FFFF); rd(0, v); check("R2 id unchanged", v, IDW);
    wr(2, 4'hF, 32'h1234_5678); rd(2, v); check("R2 class unchanged", v, CLW);
    wr(3, 4'hF, 32'hAABB_CCDD); rd(3, v); check("R2 byte 0x0E kept", v, 32'hAA00_CCDD);
    wr(15, 4'hF, 32'h1122_3344); rd(15, v); check("R2 byte 0x3D kept", v, 32'h1122_0144);
    // R10 byte lanes
    wr(16, 4'b0101, 32'hA1B2_C3D4); rd(16, v); check("R10 lanes", v, 32'h00B2_00D4);
    // R3 + R5 I/O BAR
    wr(4, 4'hF, 32'h0000_C123); rd(4, v); check("R3 bar0 masked", v, 32'h0000_C121);
    settle(); check("R5 io disabled", 32'(bar_valid), 32'h0);
    wr(1, 4'b0001, 32'h1); settle();
    check("R5 io enabled", 32'(bar_valid), 32'h01);
    check("R8 bar0 base", bar_base[31:0], 32'h0000_C120);
    // R6 unwritten I/O BAR3 has base zero
    check("R6 bar3 base zero", 32'(bar_valid[3]), 32'h0);
    probe(32'h0000_C12F, 1); check("R9 io hit", 32'(hit), 32'h01);
    probe(32'h0000_C130, 1); check("R9 io miss", 32'(hit), 32'h00);
    probe(32'h0000_C12F, 0); check("R9 space mismatch", 32'(hit), 32'h00);
    // R3 + R7 memory BAR
    wr(5, 4'hF, 32'h8000_1FFF); rd(5, v); check("R3 bar1 masked", v, 32'h8000_1008);
    settle(); check("R5 mem disabled", 32'(bar_valid[1]), 32'h0);
    wr(1, 4'b0001, 32'h3); settle();
    check("R7 bar1 valid", 32'(bar_valid[1]), 32'h1);
    check("R7 bar1 base", bar_base[63:32], 32'h8000_1000);
    probe(32'h8000_1ABC, 0); check("R9 mem hit", 32'(hit), 32'h02);
    wr(8, 4'hF, 32'hFFF0_0000); settle(); check("R7 end all ones", 32'(bar_valid[4]), 32'h0);
    wr(8, 4'hF, 32'hFFE0_0000); settle(); check("R7 bar4 valid", 32'(bar_valid[4]), 32'h1);
    check("R7 bar4 base", bar_base[159:128], 32'hFFE0_0000);
    // R6 I/O limits
    wr(4, 4'hF, 32'h0000_FFF5); settle(); check("R6 top of io", 32'(bar_valid[0]), 32'h1);
    check("R6 base", bar_base[31:0], 32'h0000_FFF0);
    wr(4, 4'hF, 32'h0001_0000); settle(); check("R6 beyond 64K", 32'(bar_valid[0]), 32'h0);
    wr(4, 4'hF, 32'h0000_000F); settle(); check("R6 base zero", 32'(bar_valid[0]), 32'h0);
    wr(4, 4'hF, 32'h0000_FFF0); settle(); check("R6 restored", 32'(bar_valid[0]), 32'h1);
    // R4 partial BAR write, R8 no remap until command touch
    wr(4, 4'b0010, 32'h0000_2000); rd(4, v); check("R4 raw partial", v, 32'h0000_20F1);
    settle(); check("R8 no remap", bar_base[31:0], 32'h0000_FFF0);
    wr(1, 4'b0010, 32'h0); settle();
    check("R8 remap via byte 5", bar_base[31:0], 32'h0000_20F0);
    check("R8 still valid", 32'(bar_valid[0]), 32'h1);
    // R4 size-0 BAR, R9 never hits
    wr(6, 4'hF, 32'h1234_5678); rd(6, v); check("R4 raw unimpl", v, 32'h1234_5678);
    wr(1, 4'b0001, 32'h3); settle();
    check("R9 unimpl invalid", 32'(bar_valid[2]), 32'h0);
    probe(32'h1234_5678, 0); check("R9 unimpl no hit mem", 32'(hit), 32'h00);
    probe(32'h1234_5678, 1); check("R9 unimpl no hit io", 32'(hit), 32'h00);
    // R5 disable I/O only
    wr(1, 4'b0001, 32'h2); settle();
    check("R5 io off", 32'(bar_valid[0]), 32'h0);
    check("R5 mem kept", 32'(bar_valid[1]), 32'h1);
    probe(32'h0000_20F0, 1); check("R9 disabled no hit", 32'(hit), 32'h00);
    // R7 memory base zero
    wr(5, 4'hF, 32'h0000_0000); rd(5, v); check("R3 type kept", v, 32'h8);
    settle(); check("R7 mem base zero", 32'(bar_valid[1]), 32'h0);
    repeat (3) settle();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule